// File: doc/BRIEF.md
# Script Transfer Condition Unit

This unit sits in the execute stage of a bus-protocol script engine. It handles jump, call, return and interrupt instructions. For each such instruction it decides whether the transfer is taken, and it works out where execution continues. The engine pulses `start` with the instruction word, the program counter (already advanced past the instruction) and the instruction's 32-bit operand. The unit replies with a one-cycle `done` pulse. With `done` it presents the decision, the next execution address, an illegal-encoding flag, and either a halt request or an interrupt-on-the-fly notice.

Three kinds of test can feed the condition: a comparison of the latched bus phase (or, in target mode, the attention line), a comparison of the first received data byte, and a test of the ALU carry. One polarity bit decides whether a true or a false result causes the transfer. The instruction can also ask the unit to wait for a new, unserviced bus phase before it compares. While it waits, `busy` stays high and further `start` pulses are ignored. Targets are either the operand taken as an absolute address or the program counter plus a signed 24-bit offset.

Instruction word fields used: kind in bits 31:27, phase field in 26:24, relative select in bit 23, carry test in bit 21, non-halting interrupt in bit 20, polarity in bit 19, data compare in bit 18, phase compare in bit 17, wait-for-phase in bit 16, data field in 7:0. Bits 22 and 15:8 are reserved.

Top module: `branch_decider`

## Requirements
- R1: After reset, busy, done, taken, illegal, haltReq and intOnFly are 0 and nextAddr is 0.
- R2: A start accepted with bit 16 clear gives done high in the cycle after the start edge, and busy stays low.
- R3: A start accepted with bit 16 set raises busy from the next cycle. A phaseValid seen on the start edge does not count. The decision is made on the first later edge with phaseValid high, and done rises (busy falls) in the cycle after that edge. Any start that arrives while busy is ignored.
- R4: Bit 19 is the polarity: 1 takes the transfer when the condition is true, 0 when it is false. With bits 21, 18 and 17 all clear, the transfer is taken exactly when bit 19 is 1.
- R5: With bit 18 set, the data test is true when firstByte equals instruction bits 7:0.
- R6: With bit 17 set, the phase test is true when busPhase equals bits 26:24 (targetMode=0), or when atnActive is 1 (targetMode=1).
- R7: With both bits 17 and 18 set, polarity 1 needs both tests true and polarity 0 needs both tests false.
- R8: With bit 21 set (and 17, 18 clear), the condition is aluCarry.
- R9: Bit 21 together with bit 17 or 18, or any nonzero reserved bit (22, 15:8), sets illegal with done and forces taken to 0.
- R10: On a taken decision nextAddr is operandWord when bit 23 is 0. When bit 23 is 1 it is pcValue plus operandWord[23:0] sign-extended, modulo 2^32. On a not-taken decision it is pcValue. taken, illegal and nextAddr hold until the next decision.
- R11: A taken transfer of kind 5'b10011 (interrupt) pulses haltReq with done when bit 20 is 0, or intOnFly with done when bit 20 is 1. Other kinds raise neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Instruction present for evaluation |
| instrWord | input | 32 | Transfer-control instruction word |
| pcValue | input | 32 | Program counter after the instruction |
| operandWord | input | 32 | Absolute target or signed offset in bits 23:0 |
| busPhase | input | 3 | Latched bus phase |
| firstByte | input | 8 | First received data byte |
| aluCarry | input | 1 | ALU carry flag |
| targetMode | input | 1 | 1 when the engine acts as target |
| atnActive | input | 1 | Attention line active (target mode) |
| phaseValid | input | 1 | A new unserviced phase is present |
| busy | output | 1 | Waiting for a valid phase |
| done | output | 1 | Decision outputs updated this cycle |
| taken | output | 1 | Transfer taken |
| nextAddr | output | 32 | Next execution address |
| illegal | output | 1 | Illegal condition encoding |
| haltReq | output | 1 | Halting interrupt pulse |
| intOnFly | output | 1 | Non-halting interrupt pulse |

## Verification
With bit 16 clear, a decision is due one cycle after the start edge. With bit 16 set, busy is due one cycle after start, and the decision one cycle after the first later edge that sees phaseValid. haltReq and intOnFly are due only in the done cycle. The bench drives inputs shortly after each rising edge. On that same edge its reference model advances, using the inputs that the design also samples. Every output is compared with the model at the following falling edge, so each result is checked in exactly the cycle it is due, and also in every cycle before and after.

// File: rtl/branch_pkg.sv
package branch_pkg;
  localparam int INSTR_W  = 32;
  localparam int PHASE_W  = 3;
  localparam int DATA_W   = 8;
  localparam int KIND_HI  = 31;
  localparam int KIND_LO  = 27;
  localparam int PHASE_HI = 26;
  localparam int PHASE_LO = PHASE_HI - PHASE_W + 1;
  localparam int BIT_REL   = 23;
  localparam int BIT_CARRY = 21;
  localparam int BIT_IOF   = 20;
  localparam int BIT_POL   = 19;
  localparam int BIT_DATA  = 18;
  localparam int BIT_PHASE = 17;
  localparam int BIT_WAIT  = 16;
  localparam logic [KIND_HI-KIND_LO:0] KIND_INT = 5'b10011;
  localparam logic [INSTR_W-1:0] RSVD_MASK = 32'h0040_FF00;

  typedef struct packed {
    logic latchInstr;
    logic evalNow;
    logic useLatched;
  } ctrlStrobe_t;
endpackage

// File: rtl/branch_cond.sv
module branch_cond
  import branch_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic [PHASE_W-1:0] busPhase,
  input  logic [DATA_W-1:0]  firstByte,
  input  logic               aluCarry,
  input  logic               targetMode,
  input  logic               atnActive,
  output logic               condTaken,
  output logic               condIllegal
);
  logic carryEn, dataEn, phaseEn, polarity;
  logic phaseHit, dataHit, allTrue, allFalse;

  assign carryEn  = instr[BIT_CARRY];
  assign dataEn   = instr[BIT_DATA];
  assign phaseEn  = instr[BIT_PHASE];
  assign polarity = instr[BIT_POL];
  assign phaseHit = targetMode ? atnActive : (busPhase == instr[PHASE_HI:PHASE_LO]);
  assign dataHit  = (firstByte == instr[DATA_W-1:0]);
  assign allTrue  = (!phaseEn || phaseHit) && (!dataEn || dataHit);
  assign allFalse = (!phaseEn || !phaseHit) && (!dataEn || !dataHit);

  always_comb begin
    condIllegal = (carryEn && (dataEn || phaseEn)) || (|(instr & RSVD_MASK));
    if (condIllegal)
      condTaken = 1'b0;
    else if (carryEn)
      condTaken = (aluCarry == polarity);
    else if (!dataEn && !phaseEn)
      condTaken = polarity;
    else
      condTaken = polarity ? allTrue : allFalse;
  end
endmodule

// File: rtl/branch_control.sv
module branch_control
  import branch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        waitBit,
  input  logic        phaseValid,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;
  state_t state;

  always_comb begin
    strobe.latchInstr = (state == ST_IDLE) && start && waitBit;
    strobe.evalNow    = ((state == ST_IDLE) && start && !waitBit) ||
                        ((state == ST_WAIT) && phaseValid);
    strobe.useLatched = (state == ST_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start && waitBit) state <= ST_WAIT;
        ST_WAIT: if (phaseValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_WAIT);

  // R3: a waiting start makes the unit busy on the next cycle
  p_enter_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && waitBit) |=> busy);
  // R3: busy holds until a phase strobe arrives
  p_stay_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !phaseValid) |=> busy);
  // R3: busy drops after the phase strobe
  p_leave_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phaseValid) |=> !busy);
endmodule

// File: rtl/branch_datapath.sv
module branch_datapath
  import branch_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  pcValue,
  input  logic [ADDR_W-1:0]  operandWord,
  input  logic [PHASE_W-1:0] busPhase,
  input  logic [DATA_W-1:0]  firstByte,
  input  logic               aluCarry,
  input  logic               targetMode,
  input  logic               atnActive,
  output logic               done,
  output logic               taken,
  output logic               illegal,
  output logic               haltReq,
  output logic               intOnFly,
  output logic [ADDR_W-1:0]  nextAddr
);
  logic [INSTR_W-1:0] holdInstr, curInstr;
  logic [ADDR_W-1:0]  holdPc, holdOp, curPc, curOp;
  logic [ADDR_W-1:0]  offExt, relTarget, target;
  logic               condTaken, condIllegal, isIntKind;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdInstr <= '0;
      holdPc    <= '0;
      holdOp    <= '0;
    end else if (strobe.latchInstr) begin
      holdInstr <= instrWord;
      holdPc    <= pcValue;
      holdOp    <= operandWord;
    end
  end

  assign curInstr = strobe.useLatched ? holdInstr : instrWord;
  assign curPc    = strobe.useLatched ? holdPc    : pcValue;
  assign curOp    = strobe.useLatched ? holdOp    : operandWord;

  generate
    if (OFFSET_W < ADDR_W) begin : g_sext
      assign offExt = {{(ADDR_W-OFFSET_W){curOp[OFFSET_W-1]}}, curOp[OFFSET_W-1:0]};
    end else begin : g_full
      assign offExt = curOp;
    end
  endgenerate

  assign relTarget = curPc + offExt;
  assign target    = curInstr[BIT_REL] ? relTarget : curOp;
  assign isIntKind = (curInstr[KIND_HI:KIND_LO] == KIND_INT);

  branch_cond u_cond (
    .instr      (curInstr),
    .busPhase   (busPhase),
    .firstByte  (firstByte),
    .aluCarry   (aluCarry),
    .targetMode (targetMode),
    .atnActive  (atnActive),
    .condTaken  (condTaken),
    .condIllegal(condIllegal)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      taken    <= 1'b0;
      illegal  <= 1'b0;
      haltReq  <= 1'b0;
      intOnFly <= 1'b0;
      nextAddr <= '0;
    end else begin
      done     <= strobe.evalNow;
      haltReq  <= 1'b0;
      intOnFly <= 1'b0;
      if (strobe.evalNow) begin
        taken    <= condTaken;
        illegal  <= condIllegal;
        nextAddr <= condTaken ? target : curPc;
        haltReq  <= condTaken && isIntKind && !curInstr[BIT_IOF];
        intOnFly <= condTaken && isIntKind &&  curInstr[BIT_IOF];
      end
    end
  end

  // R9: an illegal encoding is never taken
  p_illegal_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !taken);
  // R11: the two interrupt signals never coincide
  p_halt_iof_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(haltReq && intOnFly));
  // R11: interrupt signalling only comes with a taken decision
  p_pulse_with_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq || intOnFly) |-> (done && taken));
  // R10: an untaken decision resumes at the program counter
  p_untaken_pc_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evalNow && !condTaken) |=> (nextAddr == $past(curPc)));
endmodule

// File: rtl/branch_decider.sv
module branch_decider
  import branch_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  pcValue,
  input  logic [ADDR_W-1:0]  operandWord,
  input  logic [PHASE_W-1:0] busPhase,
  input  logic [DATA_W-1:0]  firstByte,
  input  logic               aluCarry,
  input  logic               targetMode,
  input  logic               atnActive,
  input  logic               phaseValid,
  output logic               busy,
  output logic               done,
  output logic               taken,
  output logic [ADDR_W-1:0]  nextAddr,
  output logic               illegal,
  output logic               haltReq,
  output logic               intOnFly
);
  ctrlStrobe_t strobe;

  branch_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .waitBit   (instrWord[BIT_WAIT]),
    .phaseValid(phaseValid),
    .strobe    (strobe),
    .busy      (busy)
  );

  branch_datapath #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .instrWord  (instrWord),
    .pcValue    (pcValue),
    .operandWord(operandWord),
    .busPhase   (busPhase),
    .firstByte  (firstByte),
    .aluCarry   (aluCarry),
    .targetMode (targetMode),
    .atnActive  (atnActive),
    .done       (done),
    .taken      (taken),
    .illegal    (illegal),
    .haltReq    (haltReq),
    .intOnFly   (intOnFly),
    .nextAddr   (nextAddr)
  );

  // R2: an immediate start yields done on the next cycle without busy
  p_imm_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !instrWord[BIT_WAIT]) |=> (done && !busy));
  // R3: the phase strobe while waiting yields done next cycle
  p_wait_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phaseValid) |=> done);
  // R3: no decision while still waiting
  p_no_early_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !phaseValid) |=> !done);
endmodule

// File: tb/branch_decider_bench.sv
`timescale 1ns/1ps
module branch_decider_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] pcValue = '0;
  logic [31:0] operandWord = '0;
  logic [2:0]  busPhase = '0;
  logic [7:0]  firstByte = '0;
  logic        aluCarry = 1'b0;
  logic        targetMode = 1'b0;
  logic        atnActive = 1'b0;
  logic        phaseValid = 1'b0;
  logic        busy, done, taken, illegal, haltReq, intOnFly;
  logic [31:0] nextAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  branch_decider u_branch_decider (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .pcValue(pcValue), .operandWord(operandWord), .busPhase(busPhase),
    .firstByte(firstByte), .aluCarry(aluCarry), .targetMode(targetMode),
    .atnActive(atnActive), .phaseValid(phaseValid), .busy(busy), .done(done),
    .taken(taken), .nextAddr(nextAddr), .illegal(illegal),
    .haltReq(haltReq), .intOnFly(intOnFly)
  );

  // reference model state
  bit        mBusy = 0, mDone = 0, mTaken = 0, mIll = 0, mHalt = 0, mIof = 0;
  bit [31:0] mNext = 0;
  bit [31:0] sInstr = 0, sPc = 0, sOp = 0;

  localparam bit [4:0] K_JMP = 5'b10000;
  localparam bit [4:0] K_CALL = 5'b10001;
  localparam bit [4:0] K_INT = 5'b10011;

  function automatic bit [31:0] mk(bit [4:0] kind, bit rel, bit car, bit iof,
                                   bit pol, bit cd, bit cp, bit wt,
                                   bit [2:0] ph, bit [7:0] dat);
    bit [31:0] w = '0;
    w[31:27] = kind; w[26:24] = ph; w[23] = rel; w[21] = car; w[20] = iof;
    w[19] = pol; w[18] = cd; w[17] = cp; w[16] = wt; w[7:0] = dat;
    return w;
  endfunction

  task automatic decide(input bit [31:0] w, input bit [31:0] pc, input bit [31:0] op);
    int nEn = 0;
    int nHit = 0;
    bit tk;
    bit il;
    il = (w[21] && (w[17] || w[18])) || w[22] || (w[15:8] != 8'd0);
    if (il) tk = 0;
    else if (w[21]) tk = (aluCarry == w[19]);
    else begin
      if (w[18]) begin nEn++; if (firstByte == w[7:0]) nHit++; end
      if (w[17]) begin
        nEn++;
        if (targetMode ? atnActive : (busPhase == w[26:24])) nHit++;
      end
      if (nEn == 0) tk = w[19];
      else if (w[19]) tk = (nHit == nEn);
      else tk = (nHit == 0);
    end
    mDone = 1; mTaken = tk; mIll = il;
    if (!tk) mNext = pc;
    else if (w[23]) mNext = pc + {{8{op[23]}}, op[23:0]};
    else mNext = op;
    mHalt = tk && (w[31:27] == K_INT) && !w[20];
    mIof  = tk && (w[31:27] == K_INT) &&  w[20];
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mTaken = 0; mIll = 0; mHalt = 0; mIof = 0; mNext = 0;
    end else begin
      mDone = 0; mHalt = 0; mIof = 0;
      if (!mBusy) begin
        if (start) begin
          if (instrWord[16]) begin
            mBusy = 1; sInstr = instrWord; sPc = pcValue; sOp = operandWord;
          end else decide(instrWord, pcValue, operandWord);
        end
      end else if (phaseValid) begin
        decide(sInstr, sPc, sOp);
        mBusy = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        chk(busy === 1'b0 && done === 1'b0 && taken === 1'b0 && illegal === 1'b0 &&
            haltReq === 1'b0 && intOnFly === 1'b0 && nextAddr === 32'd0,
            "R1 reset state",
            {25'd0, busy, done, taken, illegal, haltReq, intOnFly, 1'b0} | nextAddr, 32'd0);
      end else begin
        chk(busy === mBusy, "R3 busy", {31'd0, busy}, {31'd0, mBusy});
        chk(done === mDone, "R2 R3 done timing", {31'd0, done}, {31'd0, mDone});
        chk(taken === mTaken, "R4 R5 R6 R7 R8 taken", {31'd0, taken}, {31'd0, mTaken});
        chk(illegal === mIll, "R9 illegal", {31'd0, illegal}, {31'd0, mIll});
        chk(nextAddr === mNext, "R10 nextAddr", nextAddr, mNext);
        chk(haltReq === mHalt, "R11 haltReq", {31'd0, haltReq}, {31'd0, mHalt});
        chk(intOnFly === mIof, "R11 intOnFly", {31'd0, intOnFly}, {31'd0, mIof});
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic env(bit [2:0] ph, bit [7:0] b, bit c, bit tm, bit atn);
    busPhase = ph; firstByte = b; aluCarry = c; targetMode = tm; atnActive = atn;
  endtask

  task automatic issue(bit [31:0] w, bit [31:0] pc, bit [31:0] op);
    @(posedge clk); #2;
    instrWord = w; pcValue = pc; operandWord = op; start = 1;
    @(posedge clk); #2;
    start = 0;
    repeat (2) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R3 watchdog expired: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R4: unconditional and never transfers
    env(3'd0, 8'h00, 0, 0, 0);
    issue(mk(K_JMP, 0, 0, 0, 1, 0, 0, 0, 3'd0, 8'h00), 32'h0000_1000, 32'h0000_8000);
    issue(mk(K_JMP, 0, 0, 0, 0, 0, 0, 0, 3'd0, 8'h00), 32'h0000_1008, 32'h0000_8000);
    // R5: data compare both polarities
    env(3'd1, 8'h5A, 0, 0, 0);
    issue(mk(K_CALL, 0, 0, 0, 1, 1, 0, 0, 3'd0, 8'h5A), 32'h100, 32'h2000);
    issue(mk(K_CALL, 0, 0, 0, 1, 1, 0, 0, 3'd0, 8'h5B), 32'h108, 32'h2000);
    issue(mk(K_CALL, 0, 0, 0, 0, 1, 0, 0, 3'd0, 8'h5B), 32'h110, 32'h2040);
    // R6: phase compare initiator and target
    env(3'd6, 8'h00, 0, 0, 0);
    issue(mk(K_JMP, 0, 0, 0, 1, 0, 1, 0, 3'd6, 8'h00), 32'h200, 32'h3000);
    issue(mk(K_JMP, 0, 0, 0, 1, 0, 1, 0, 3'd2, 8'h00), 32'h208, 32'h3000);
    env(3'd2, 8'h00, 0, 1, 1);
    issue(mk(K_JMP, 0, 0, 0, 1, 0, 1, 0, 3'd0, 8'h00), 32'h210, 32'h3100);
    env(3'd2, 8'h00, 0, 1, 0);
    issue(mk(K_JMP, 0, 0, 0, 1, 0, 1, 0, 3'd2, 8'h00), 32'h218, 32'h3100);
    // R7: combined tests
    env(3'd4, 8'hC3, 0, 0, 0);
    issue(mk(K_JMP, 0, 0, 0, 1, 1, 1, 0, 3'd4, 8'hC3), 32'h300, 32'h4000);
    issue(mk(K_JMP, 0, 0, 0, 1, 1, 1, 0, 3'd4, 8'hC0), 32'h308, 32'h4000);
    issue(mk(K_JMP, 0, 0, 0, 0, 1, 1, 0, 3'd4, 8'hC0), 32'h310, 32'h4000);
    issue(mk(K_JMP, 0, 0, 0, 0, 1, 1, 0, 3'd1, 8'hC0), 32'h318, 32'h4040);
    // R8: carry test
    env(3'd0, 8'h00, 1, 0, 0);
    issue(mk(K_JMP, 0, 1, 0, 1, 0, 0, 0, 3'd0, 8'h00), 32'h400, 32'h5000);
    issue(mk(K_JMP, 0, 1, 0, 0, 0, 0, 0, 3'd0, 8'h00), 32'h408, 32'h5000);
    env(3'd0, 8'h00, 0, 0, 0);
    issue(mk(K_JMP, 0, 1, 0, 0, 0, 0, 0, 3'd0, 8'h00), 32'h410, 32'h5040);
    // R9: illegal mixes and reserved bits
    issue(mk(K_JMP, 0, 1, 0, 1, 1, 0, 0, 3'd0, 8'h00), 32'h500, 32'h6000);
    issue(mk(K_JMP, 0, 1, 0, 0, 0, 1, 0, 3'd1, 8'h00), 32'h508, 32'h6000);
    issue(mk(K_JMP, 0, 0, 0, 1, 0, 0, 0, 3'd0, 8'h00) | 32'h0000_0100, 32'h510, 32'h6000);
    issue(mk(K_JMP, 0, 0, 0, 1, 0, 0, 0, 3'd0, 8'h00) | 32'h0040_0000, 32'h518, 32'h6000);
    // R10: relative forward, backward, wrap
    issue(mk(K_JMP, 1, 0, 0, 1, 0, 0, 0, 3'd0, 8'h00), 32'h0010_0000, 32'hAB00_0040);
    issue(mk(K_JMP, 1, 0, 0, 1, 0, 0, 0, 3'd0, 8'h00), 32'h0010_0000, 32'h00FF_FFF0);
    issue(mk(K_JMP, 1, 0, 0, 1, 0, 0, 0, 3'd0, 8'h00), 32'h0000_0008, 32'h0080_0000);
    issue(mk(K_JMP, 1, 0, 0, 1, 0, 0, 0, 3'd0, 8'h00), 32'hFFFF_FFF8, 32'h0000_0010);
    // R11: interrupt halting, non-halting, untaken, other kind
    issue(mk(K_INT, 0, 0, 0, 1, 0, 0, 0, 3'd0, 8'h00), 32'h700, 32'h0);
    issue(mk(K_INT, 0, 0, 1, 1, 0, 0, 0, 3'd0, 8'h00), 32'h708, 32'h0);
    issue(mk(K_INT, 0, 0, 1, 0, 0, 0, 0, 3'd0, 8'h00), 32'h710, 32'h0);
    issue(mk(K_CALL, 0, 0, 1, 1, 0, 0, 0, 3'd0, 8'h00), 32'h718, 32'h9000);
    // R3: wait for phase, strobe on start edge ignored, start while busy ignored
    env(3'd2, 8'h00, 0, 0, 0);
    @(posedge clk); #2;
    instrWord = mk(K_JMP, 0, 0, 0, 1, 0, 1, 1, 3'd5, 8'h00);
    pcValue = 32'h800; operandWord = 32'hA000; start = 1; phaseValid = 1;
    @(posedge clk); #2;
    start = 0; phaseValid = 0;
    instrWord = 32'h0; pcValue = 32'h0; operandWord = 32'h0;
    repeat (3) @(posedge clk);
    #2;
    instrWord = mk(K_JMP, 0, 0, 0, 1, 0, 0, 0, 3'd0, 8'h00);
    pcValue = 32'h900; operandWord = 32'hB000; start = 1;
    @(posedge clk); #2;
    start = 0;
    repeat (2) @(posedge clk);
    #2 busPhase = 3'd5; phaseValid = 1;
    @(posedge clk); #2;
    phaseValid = 0;
    repeat (3) @(posedge clk);
    // R3: waiting data compare in target mode, mismatching
    #2 env(3'd0, 8'h11, 0, 1, 1);
    issue(mk(K_JMP, 0, 0, 0, 1, 1, 0, 1, 3'd0, 8'h22), 32'hC00, 32'hD000);
    phaseValid = 1;
    @(posedge clk); #2;
    phaseValid = 0;
    repeat (3) @(posedge clk);
    // R1: reset in the middle of a wait
    #2;
    instrWord = mk(K_JMP, 0, 0, 0, 1, 0, 0, 1, 3'd0, 8'h00); start = 1;
    @(posedge clk); #2;
    start = 0;
    @(posedge clk); #2;
    rstN = 0;
    repeat (2) @(posedge clk);
    #2 rstN = 1;
    repeat (4) @(posedge clk);
    #1;
    summary();
    $finish;
  end
endmodule